// File: doc/BRIEF.md
# Up/Down Compare Timer

This block is a compare timer with a center-aligned time base. Its counter climbs from zero to a programmable period value and then falls back to zero, so one cycle lasts twice the period value in clocks. Each compare channel watches the count and drives one output pin through its own output mode. Two channels, one in toggle/set and the other in toggle/reset, give a complementary pair for the two legs of a half-bridge. The gap between the two compare values sets the dead time.

Compare values are written into shadow registers over a simple register bus. A shadow value moves into the live compare register only while the count is zero, so both channels switch to new values together at the cycle boundary. A late write therefore never drops an edge or adds one. A sticky flag marks every return of the count to zero. Other counting modes are up-only, free-running and stopped, and a clear bit restarts the count.

Top module: `udt_timer`

## Requirements
- R1: During reset and right after it, the count is 0, counting is stopped, the zero flag is low and every output is low.
- R2: In up/down mode (run code 3), a period value P > 0 makes the count follow 0,1,…,P,P-1,…,1,0 and repeat, so one cycle is 2·P clocks. With P = 0 the count stays at 0.
- R3: The run field is bits [1:0] of the control word at address 0: 0 stops and holds the count, 1 counts 0..P and wraps to 0, 2 counts freely with wrap at the counter width, 3 is up/down. A control write replaces the field, so writing 0 stops a running timer.
- R4: A control write with bit 2 set forces the count to 0. Counting then continues upward from 0 in the newly written mode.
- R5: The zero flag rises in the same cycle that the count output turns 0 from a nonzero value while running. It stays high until a control write with bit 3 set. If a set and a clear arrive in the same cycle, the set wins.
- R6: Writes to compare channel n go to address 3+n and land in a shadow register. The live compare takes the shadow value only while the count is 0, so a rewrite in mid-cycle changes nothing before the next zero.
- R7: Output mode 1 (toggle/set), with compare C where 0 < C < P: the output toggles when the count equals C and is set when the count equals P. Every output changes one clock after the count shows the matching value.
- R8: Output mode 2 (toggle/reset): the output toggles when the count equals C and is cleared when the count equals P. After the first period event it is the exact complement of mode 1 with the same C.
- R9: A compare value of 0, or one that is at least P, never toggles the output. A mode-1 output holds high and a mode-2 output holds low from the first period event on.
- R10: Output modes sit in the word at address 2, two bits per channel, with channel n in bits [2n+1:2n]. Mode 0 drives the output low. Mode 3 sets the output at an in-range compare match and clears it at the period value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register address: 0 control, 1 period, 2 output modes, 3+n compare shadow n |
| wr_data | input | CW (16) | Write data |
| count_o | output | CW (16) | Current count |
| zero_flag_o | output | 1 | Sticky zero-reached flag |
| pwm_o | output | NCH (2) | Compare outputs, bit n from channel n |

## Verification
Assertions check the following on every cycle:
- A stopped counter holds its value.
- A clear leaves zero.
- An up/down count moves by exactly one step.
- Up mode wraps at the period.
- The flag rises only at zero and falls only after a clear request.
- The live compare never changes away from zero.
- An idle output stays low.
- An out-of-range compare never moves an output except at the period.

The bench sweeps every compare value from 0 to P+1 for several small periods and checks the exact waveform of both complementary outputs against arithmetic expectations. It also checks mid-cycle shadow rewrites, the set/reset and idle modes, and the non-up/down run modes.

// File: rtl/udt_pkg.sv
package udt_pkg;
  typedef enum logic [1:0] {
    RUN_STOP = 2'd0,
    RUN_UP   = 2'd1,
    RUN_CONT = 2'd2,
    RUN_UPDN = 2'd3
  } run_e;

  typedef enum logic [1:0] {
    OM_IDLE    = 2'd0,
    OM_TGL_SET = 2'd1,
    OM_TGL_RST = 2'd2,
    OM_SET_RST = 2'd3
  } omode_e;

  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_PERIOD = 1;
  localparam int unsigned ADDR_OMODE  = 2;
  localparam int unsigned ADDR_CMP0   = 3;
  localparam int unsigned CTL_CLR_BIT  = 2;
  localparam int unsigned CTL_FCLR_BIT = 3;
endpackage

// File: rtl/udt_rst_sync.sv
module udt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/udt_regs.sv
module udt_regs
  import udt_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  output run_e                    run_o,
  output logic [CW-1:0]           period_o,
  output logic [NCH-1:0][1:0]     omode_o,
  output logic [NCH-1:0][CW-1:0]  shadow_o,
  output logic                    clr_o,
  output logic                    fclr_o
);
  logic                   ctrl_sel, per_sel, om_sel;
  run_e                   run_q, run_d;
  logic [CW-1:0]          per_q, per_d;
  logic [NCH-1:0][1:0]    om_q, om_d;
  logic [NCH-1:0][CW-1:0] sh_q, sh_d;

  assign ctrl_sel = wr_en && (wr_addr == AW'(ADDR_CTRL));
  assign per_sel  = wr_en && (wr_addr == AW'(ADDR_PERIOD));
  assign om_sel   = wr_en && (wr_addr == AW'(ADDR_OMODE));

  always_comb begin
    run_d = run_q;
    per_d = per_q;
    om_d  = om_q;
    sh_d  = sh_q;
    if (ctrl_sel) run_d = run_e'(wr_data[1:0]);
    if (per_sel)  per_d = wr_data;
    for (int i = 0; i < int'(NCH); i++) begin
      if (om_sel) om_d[i] = wr_data[2*i +: 2];
      if (wr_en && (wr_addr == AW'(ADDR_CMP0 + i))) sh_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= RUN_STOP;
      per_q <= '0;
      om_q  <= '0;
      sh_q  <= '0;
    end else begin
      run_q <= run_d;
      per_q <= per_d;
      om_q  <= om_d;
      sh_q  <= sh_d;
    end
  end

  assign run_o    = run_q;
  assign period_o = per_q;
  assign omode_o  = om_q;
  assign shadow_o = sh_q;
  assign clr_o    = ctrl_sel && wr_data[CTL_CLR_BIT];
  assign fclr_o   = ctrl_sel && wr_data[CTL_FCLR_BIT];

  // R3: a control write with run code 0 always halts counting
  p_stop_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sel && wr_data[1:0] == 2'd0) |=> (run_o == RUN_STOP));
endmodule

// File: rtl/udt_counter.sv
module udt_counter
  import udt_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  run_e          run_i,
  input  logic [CW-1:0] period_i,
  input  logic          clr_i,
  input  logic          fclr_i,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;
  logic          flag_q, flag_d;
  logic          running, zero_hit;

  assign running = (run_i != RUN_STOP);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (clr_i) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else begin
      unique case (run_i)
        RUN_STOP: begin
          cnt_d = cnt_q;
        end
        RUN_UP: begin
          up_d  = 1'b1;
          cnt_d = (cnt_q >= period_i) ? '0 : cnt_q + ONE;
        end
        RUN_CONT: begin
          up_d  = 1'b1;
          cnt_d = cnt_q + ONE;
        end
        RUN_UPDN: begin
          if (period_i == '0) begin
            cnt_d = '0;
            up_d  = 1'b1;
          end else if (up_q) begin
            if (cnt_q >= period_i) begin
              cnt_d = cnt_q - ONE;
              up_d  = 1'b0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_d = ONE;
              up_d  = 1'b1;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  assign zero_hit = running && !clr_i && (cnt_q != '0) && (cnt_d == '0);

  always_comb begin
    flag_d = flag_q;
    if (fclr_i)   flag_d = 1'b0;
    if (zero_hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R3: a stopped counter holds its value
  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i == RUN_STOP && !clr_i) |=> $stable(cnt_q));
  // R3: up mode wraps to zero after the period value
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i == RUN_UP && !clr_i && cnt_q == period_i) |=> (cnt_q == '0));
  // R2: inside the window an up/down count moves by exactly one
  p_updn_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i == RUN_UPDN && !clr_i && cnt_q != '0 && cnt_q < period_i)
    |=> (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE));
  // R4: a clear request always leaves a zero count
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  // R5: the flag rises only together with a zero count
  p_flag_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (cnt_q == '0));
  // R5: the flag falls only after a clear request
  p_flag_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(fclr_i));
endmodule

// File: rtl/udt_channel.sv
module udt_channel
  import udt_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] shadow_i,
  input  omode_e        omode_i,
  output logic          out_o
);
  logic [CW-1:0] cmp_q, cmp_d;
  logic          out_q, out_d;
  logic          in_range, hit_cmp, hit_per;

  assign in_range = (cmp_q != '0) && (cmp_q < period_i);
  assign hit_cmp  = running_i && in_range && (cnt_i == cmp_q);
  assign hit_per  = running_i && (cnt_i == period_i);

  always_comb begin
    cmp_d = (cnt_i == '0) ? shadow_i : cmp_q;
  end

  always_comb begin
    out_d = out_q;
    unique case (omode_i)
      OM_IDLE:    out_d = 1'b0;
      OM_TGL_SET: if (hit_per) out_d = 1'b1; else if (hit_cmp) out_d = ~out_q;
      OM_TGL_RST: if (hit_per) out_d = 1'b0; else if (hit_cmp) out_d = ~out_q;
      OM_SET_RST: if (hit_per) out_d = 1'b0; else if (hit_cmp) out_d = 1'b1;
      default:    out_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      out_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

  // R6: the live compare moves only while the count sits at zero
  p_shadow_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i != '0) |=> $stable(cmp_q));
  // R10: idle mode drives the pin low
  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (omode_i == OM_IDLE) |=> !out_q);
  // R9: an out-of-range compare never moves the pin away from the period point
  p_oor_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (omode_i != OM_IDLE && (cmp_q == '0 || cmp_q >= period_i) && cnt_i != period_i)
    |=> $stable(out_q));
endmodule

// File: rtl/udt_timer.sv
module udt_timer
  import udt_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [CW-1:0]  count_o,
  output logic           zero_flag_o,
  output logic [NCH-1:0] pwm_o
);
  logic                   rst_sn;
  run_e                   run_mode;
  logic [CW-1:0]          period;
  logic [NCH-1:0][1:0]    omode;
  logic [NCH-1:0][CW-1:0] shadow;
  logic                   clr, fclr;
  logic [CW-1:0]          cnt;
  logic                   running;

  udt_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  udt_regs #(.CW(CW), .NCH(NCH), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .run_o    (run_mode),
    .period_o (period),
    .omode_o  (omode),
    .shadow_o (shadow),
    .clr_o    (clr),
    .fclr_o   (fclr)
  );

  udt_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sn),
    .run_i    (run_mode),
    .period_i (period),
    .clr_i    (clr),
    .fclr_i   (fclr),
    .cnt_o    (cnt),
    .flag_o   (zero_flag_o)
  );

  assign running = (run_mode != RUN_STOP);

  for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
    udt_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_sn),
      .running_i (running),
      .cnt_i     (cnt),
      .period_i  (period),
      .shadow_i  (shadow[g]),
      .omode_i   (omode_e'(omode[g])),
      .out_o     (pwm_o[g])
    );
  end

  assign count_o = cnt;

  // R1: while reset is held every output pin is low
  always_comb begin
    if (!rst_sn) p_reset_quiet_r1: assert (pwm_o == '0 && !zero_flag_o);
  end
endmodule

// File: tb/udt_timer_bench.sv
module udt_timer_bench;
  localparam int CW = 16, NCH = 2, AW = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [AW-1:0]  wr_addr;
  logic [CW-1:0]  wr_data;
  logic [CW-1:0]  count_o;
  logic           zero_flag_o;
  logic [NCH-1:0] pwm_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  udt_timer #(.CW(CW), .NCH(NCH), .AW(AW)) u_udt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count_o(count_o), .zero_flag_o(zero_flag_o), .pwm_o(pwm_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int wave(int ph, int p);
    return (ph <= p) ? ph : 2*p - ph;
  endfunction

  function automatic int exp_out(int m, int ph, int q, int c, int p);
    bit inr = (c > 0) && (c < p);
    int ts = inr ? ((ph <= p) ? int'(q >= c) : int'(q > c)) : 1;
    case (m)
      1: return ts;
      2: return inr ? 1 - ts : 0;
      3: return inr ? int'(!(ph >= p && q > c)) : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string otag(int m, int c, int p, int wk);
    if (wk >= 0) return "R6 out";
    if (m != 0 && (c == 0 || c >= p)) return "R9 out";
    case (m)
      1: return "R7 out";
      2: return "R8 out";
      default: return "R10 out";
    endcase
  endfunction

  // Up/down run: channel modes m0/m1, compare c1, optional rewrite to c2 at step wk
  task automatic run_updn(int p, int c1, int c2, int m0, int m1, int wk);
    wr(0, 4);
    wr(2, 0);
    wr(1, p);
    wr(3, c1);
    wr(4, c1);
    wr(2, m0 | (m1 << 2));
    wr(0, 3 | 8);
    for (int k = 0; k <= 6*p; k++) begin
      if (k > 0) @(negedge clk);
      check("R2 count", int'(count_o), wave(k % (2*p), p));
      check("R5 flag", int'(zero_flag_o), int'(k >= 2*p));
      if (k >= p + 1) begin
        int j = k - 1;
        int ph = j % (2*p);
        int q = wave(ph, p);
        int cc = (wk >= 0 && j >= 2*p) ? c2 : c1;
        check(otag(m0, cc, p, wk), int'(pwm_o[0]), exp_out(m0, ph, q, cc, p));
        check(otag(m1, cc, p, wk), int'(pwm_o[1]), exp_out(m1, ph, q, cc, p));
      end
      if (wk >= 0 && k == wk) begin
        wr_en = 1'b1; wr_addr = AW'(3); wr_data = CW'(c2);
      end else if (wk >= 0 && k == wk + 1) begin
        wr_en = 1'b1; wr_addr = AW'(4); wr_data = CW'(c2);
      end else begin
        wr_en = 1'b0;
      end
    end
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset count", int'(count_o), 0);
    check("R1 reset flag", int'(zero_flag_o), 0);
    check("R1 reset pwm", int'(pwm_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle count", int'(count_o), 0);
    check("R1 idle pwm", int'(pwm_o), 0);
    check("R1 idle flag", int'(zero_flag_o), 0);

    // Complementary pair, full compare sweep (R2, R5, R7, R8, R9)
    for (int p = 3; p <= 6; p++)
      for (int c = 0; c <= p + 1; c++)
        run_updn(p, c, c, 1, 2, -1);

    // Shadow rewrites in mid-cycle (R6)
    run_updn(6, 2, 4, 1, 2, 7);
    run_updn(6, 4, 2, 2, 1, 9);
    // Set/reset and idle modes (R10)
    run_updn(5, 2, 2, 3, 0, -1);
    run_updn(7, 3, 3, 0, 3, -1);

    // Up mode wraps at the period (R3)
    wr(0, 4);
    wr(1, 5);
    wr(0, 1 | 8);
    for (int k = 0; k < 14; k++) begin
      if (k > 0) @(negedge clk);
      check("R3 up count", int'(count_o), k % 6);
      check("R5 up flag", int'(zero_flag_o), int'(k >= 6));
    end
    // Stop replaces the run field (R3)
    wr(0, 0);
    v = int'(count_o);
    repeat (3) @(negedge clk);
    check("R3 stop hold", int'(count_o), v);
    check("R5 flag sticky", int'(zero_flag_o), 1);
    wr(0, 8);
    check("R5 flag clear", int'(zero_flag_o), 0);

    // Free-running mode (R3) and clear while running (R4)
    wr(0, 4);
    wr(0, 2);
    for (int k = 0; k < 10; k++) begin
      if (k > 0) @(negedge clk);
      check("R3 cont count", int'(count_o), k);
    end
    wr(0, 2 | 4);
    check("R4 clear", int'(count_o), 0);
    @(negedge clk);
    check("R4 restart", int'(count_o), 1);

    // Clear in up/down restarts upward (R4)
    wr(0, 3);
    repeat (6) @(negedge clk);
    wr(0, 3 | 4);
    check("R4 updn clear", int'(count_o), 0);
    @(negedge clk);
    check("R4 updn up1", int'(count_o), 1);
    @(negedge clk);
    check("R4 updn up2", int'(count_o), 2);

    // Zero period holds the count (R2)
    wr(0, 4);
    wr(1, 0);
    wr(0, 3);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R2 zero period", int'(count_o), 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule